// File: doc/BRIEF.md
# Flash Status and Write-Protection Unit

This block keeps the 8-bit status register of a serial flash device and decides, for every modifying command, whether the command may run. It holds the write-enable latch, a 2-bit protection code that selects how much of the array is read-only, a status-lock bit and the busy flag. It also watches an active-low write-protect pin. The command decoder presents one request at a time: a kind (page program, sector erase, bulk erase or status write), a target address and, for a status write, the new register value. The unit answers in the same cycle with either a grant or a refusal.

A granted request starts a self-timed operation. The busy flag stays set until the array sequencer reports completion. Write-enable and write-disable arrive as single-cycle pulses. The protection code and lock bit are non-volatile in a real part and are modelled here as registers that reset with the block. Serial shifting and array access belong to neighbouring blocks.

Top module: `flash_wp_unit`

## Requirements
- R1: `status_o` carries the lock bit at bit 7, zeros at bits 6:4, the protection code high bit at bit 3 and low bit at bit 2, the write-enable latch at bit 1 and the busy flag at bit 0. After reset it reads 00h.
- R2: While idle (busy = 0), a `wren_i` pulse sets the write-enable latch and a `wrdi_i` pulse clears it, visible in `status_o` from the next cycle. Both pulses have no effect while busy.
- R3: Any request presented while idle clears the write-enable latch from the next cycle, whether granted or refused. A refused request leaves busy at 0.
- R4: A request presented while the write-enable latch is 0 is refused.
- R5: A granted request sets busy from the next cycle. Busy stays 1 until an `op_done_i` pulse and reads 0 the cycle after it. `op_done_i` while idle changes nothing.
- R6: A request presented while busy raises neither `req_grant_o` nor `req_refuse_o` and changes no status bit.
- R7: A granted status write (kind 3) loads bits 7, 3 and 2 of `req_wdata_i` into the same status positions. The other data bits are ignored.
- R8: When the lock bit is 1 and the synchronised pin is low, status writes are refused. This holds whichever condition became true first, and only returning the pin high releases it. The pin passes through `WP_SYNC` flops (default 2) before use.
- R9: Protection code 00 protects nothing. Code 01 protects addresses whose two top bits are 11. Code 10 protects addresses whose top bit is 1. Code 11 protects every address. Page program (kind 0) and sector erase (kind 1) aimed at a protected address are refused.
- R10: Bulk erase (kind 2) is granted only when the protection code is 00. Program and erase decisions do not depend on the pin or the lock bit.
- R11: `req_grant_o` and `req_refuse_o` are combinational answers, valid in the same cycle as `req_valid_i`. At most one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wp_n_i | input | 1 | Active-low write-protect pin, asynchronous |
| wren_i | input | 1 | Write-enable pulse |
| wrdi_i | input | 1 | Write-disable pulse |
| req_valid_i | input | 1 | Request present this cycle |
| req_kind_i | input | 2 | 0 program, 1 sector erase, 2 bulk erase, 3 status write |
| req_addr_i | input | ADDR_W | Target address for program and sector erase |
| req_wdata_i | input | 8 | New status value for a status write |
| op_done_i | input | 1 | Self-timed operation finished |
| status_o | output | 8 | Status register contents |
| req_grant_o | output | 1 | Request accepted |
| req_refuse_o | output | 1 | Request rejected |

## Verification
The in-RTL properties check the following on every cycle: how the busy flag starts and ends, that the latch is cleared after every idle request, that the lock bit and protection code stay frozen under hardware lock, and that a bulk-erase grant implies an empty protection code. Other behaviour can only be shown by the bench's scenarios. This covers the region boundaries at specific addresses, the masking of status-write data, and both orders of entering the hardware lock. It also covers release by the pin and the absence of any pin effect on program and erase.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

   typedef enum logic [1:0] {
      KIND_PROG = 2'd0,
      KIND_SECT = 2'd1,
      KIND_BULK = 2'd2,
      KIND_STAT = 2'd3
   } req_kind_e;

   localparam int STAT_WIP  = 0;
   localparam int STAT_WEL  = 1;
   localparam int STAT_BP0  = 2;
   localparam int STAT_BP1  = 3;
   localparam int STAT_LOCK = 7;

endpackage

// File: rtl/wp_pin_sync.sv
module wp_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n_i,
   output logic pin_n_o
);

   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
         $error("wp_pin_sync: STAGES must lie in 0..4");
      end

      if (STAGES == 0) begin : g_direct
         assign pin_n_o = pin_n_i;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '1;
            end else begin
               q[0] <= pin_n_i;
               for (int i = 1; i < STAGES; i++) begin
                  q[i] <= q[i-1];
               end
            end
         end
         assign pin_n_o = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/wp_region_check.sv
module wp_region_check #(
   parameter int ADDR_W = 18
) (
   input  logic [1:0]        bp_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);

   localparam int TOP = ADDR_W - 1;

   generate
      if (ADDR_W < 2) begin : g_bad_aw
         $error("wp_region_check: ADDR_W must be at least 2");
      end
   endgenerate

   logic in_top_half;
   logic in_top_quarter;

   assign in_top_half    = addr_i[TOP];
   assign in_top_quarter = addr_i[TOP] & addr_i[TOP-1];

   always_comb begin
      unique case (bp_i)
         2'b00:   hit_o = 1'b0;
         2'b01:   hit_o = in_top_quarter;
         2'b10:   hit_o = in_top_half;
         default: hit_o = 1'b1;
      endcase
   end

   // Region nesting: a quarter hit always lies inside the half region (R9)
   always_comb begin
      if (bp_i == 2'b11) begin
         a_full_r9: assert (hit_o);
      end
      if (bp_i == 2'b00) begin
         a_none_r9: assert (!hit_o);
      end
      if (bp_i == 2'b01 && hit_o) begin
         a_quarter_in_half_r9: assert (addr_i[TOP]);
      end
   end

endmodule

// File: rtl/wp_status_reg.sv
module wp_status_reg
   import flash_wp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wren_i,
   input  logic       wrdi_i,
   input  logic       req_seen_i,
   input  logic       grant_i,
   input  logic       is_stat_i,
   input  logic [7:0] wdata_i,
   input  logic       done_i,
   input  logic       hw_lock_i,
   output logic [1:0] bp_o,
   output logic       lock_o,
   output logic       wel_o,
   output logic       wip_o,
   output logic [7:0] status_o
);

   logic [1:0] bp_q;
   logic       lock_q;
   logic       wel_q;
   logic       wip_q;

   // Latch: requests take priority over enable pulses, busy freezes it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q <= 1'b0;
      end else if (!wip_q) begin
         if (req_seen_i) begin
            wel_q <= 1'b0;
         end else if (wrdi_i) begin
            wel_q <= 1'b0;
         end else if (wren_i) begin
            wel_q <= 1'b1;
         end
      end
   end

   // Protection code and lock bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_q   <= 2'b00;
         lock_q <= 1'b0;
      end else if (grant_i && is_stat_i) begin
         bp_q   <= {wdata_i[STAT_BP1], wdata_i[STAT_BP0]};
         lock_q <= wdata_i[STAT_LOCK];
      end
   end

   // Busy flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wip_q <= 1'b0;
      end else if (grant_i) begin
         wip_q <= 1'b1;
      end else if (done_i) begin
         wip_q <= 1'b0;
      end
   end

   assign bp_o   = bp_q;
   assign lock_o = lock_q;
   assign wel_o  = wel_q;
   assign wip_o  = wip_q;

   always_comb begin
      status_o            = 8'h00;
      status_o[STAT_LOCK] = lock_q;
      status_o[STAT_BP1]  = bp_q[1];
      status_o[STAT_BP0]  = bp_q[0];
      status_o[STAT_WEL]  = wel_q;
      status_o[STAT_WIP]  = wip_q;
   end

   p_wel_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_seen_i |=> !wel_q);

   p_wip_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wip_q && !done_i) |=> wip_q);

   p_wip_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip_q) |-> $past(grant_i));

   p_wip_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip_q) |-> $past(done_i));

   p_busy_latch_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wip_q |=> $stable(wel_q));

   p_locked_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hw_lock_i |=> ($stable(lock_q) && $stable(bp_q)));

endmodule

// File: rtl/flash_wp_unit.sv
module flash_wp_unit
   import flash_wp_pkg::*;
#(
   parameter int ADDR_W  = 18,
   parameter int WP_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_n_i,
   input  logic              wren_i,
   input  logic              wrdi_i,
   input  logic              req_valid_i,
   input  logic [1:0]        req_kind_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [7:0]        req_wdata_i,
   input  logic              op_done_i,
   output logic [7:0]        status_o,
   output logic              req_grant_o,
   output logic              req_refuse_o
);

   generate
      if (ADDR_W < 2) begin : g_bad_aw
         $error("flash_wp_unit: ADDR_W must be at least 2");
      end
   endgenerate

   req_kind_e  kind;
   logic       pin_n_s;
   logic [1:0] bp;
   logic       lock;
   logic       wel;
   logic       wip;
   logic       hw_lock;
   logic       region_hit;
   logic       kind_ok;
   logic       req_seen;
   logic       grant;

   assign kind = req_kind_e'(req_kind_i);

   wp_pin_sync #(.STAGES(WP_SYNC)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_n_i (wp_n_i),
      .pin_n_o (pin_n_s)
   );

   wp_region_check #(.ADDR_W(ADDR_W)) u_region (
      .bp_i   (bp),
      .addr_i (req_addr_i),
      .hit_o  (region_hit)
   );

   assign hw_lock = lock & ~pin_n_s;

   always_comb begin
      unique case (kind)
         KIND_PROG, KIND_SECT: kind_ok = ~region_hit;
         KIND_BULK:            kind_ok = (bp == 2'b00);
         default:              kind_ok = ~hw_lock;
      endcase
   end

   assign req_seen = req_valid_i & ~wip;
   assign grant    = req_seen & wel & kind_ok;

   wp_status_reg u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .wren_i     (wren_i),
      .wrdi_i     (wrdi_i),
      .req_seen_i (req_seen),
      .grant_i    (grant),
      .is_stat_i  (kind == KIND_STAT),
      .wdata_i    (req_wdata_i),
      .done_i     (op_done_i),
      .hw_lock_i  (hw_lock),
      .bp_o       (bp),
      .lock_o     (lock),
      .wel_o      (wel),
      .wip_o      (wip),
      .status_o   (status_o)
   );

   assign req_grant_o  = grant;
   assign req_refuse_o = req_seen & ~grant;

   p_answer_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_grant_o && req_refuse_o));

   p_grant_needs_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant_o |-> status_o[STAT_WEL]);

   p_busy_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && status_o[STAT_WIP]) |-> (!req_grant_o && !req_refuse_o));

   p_bulk_needs_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_grant_o && kind == KIND_BULK) |-> (status_o[STAT_BP1:STAT_BP0] == 2'b00));

   p_stat_write_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_grant_o && kind == KIND_STAT) |-> !(status_o[STAT_LOCK] && !pin_n_s));

   p_wip_after_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant_o |=> status_o[STAT_WIP]);

endmodule

// File: tb/sim_flash_wp_unit.sv
`timescale 1ns/1ps
module sim_flash_wp_unit;

   localparam int AW = 18;

   localparam logic [2:0] A_WREN = 3'd1;
   localparam logic [2:0] A_WRDI = 3'd2;
   localparam logic [2:0] A_REQ  = 3'd3;
   localparam logic [2:0] A_DONE = 3'd4;
   localparam logic [2:0] A_PIN  = 3'd5;

   localparam logic [1:0] K_P = 2'd0;
   localparam logic [1:0] K_S = 2'd1;
   localparam logic [1:0] K_B = 2'd2;
   localparam logic [1:0] K_W = 2'd3;

   // act[40:38] kind[37:36] addr[35:18] data[17:10] grant[9] refuse[8] status[7:0]
   localparam int NV = 57;
   localparam logic [40:0] VEC [NV] = '{
      {A_REQ,  K_P, 18'h00000, 8'h00, 1'b0, 1'b1, 8'h00},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h02},
      {A_WRDI, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h00},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h02},
      {A_REQ,  K_P, 18'h3FFFF, 8'h00, 1'b1, 1'b0, 8'h01},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h01},
      {A_REQ,  K_W, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h01},
      {A_DONE, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h00},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h02},
      {A_REQ,  K_W, 18'h00000, 8'hFF, 1'b1, 1'b0, 8'h8D},
      {A_DONE, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h8C},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h8E},
      {A_REQ,  K_P, 18'h00000, 8'h00, 1'b0, 1'b1, 8'h8C},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h8E},
      {A_REQ,  K_B, 18'h00000, 8'h00, 1'b0, 1'b1, 8'h8C},
      {A_PIN,  K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h8C},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h8E},
      {A_REQ,  K_W, 18'h00000, 8'h00, 1'b0, 1'b1, 8'h8C},
      {A_PIN,  K_P, 18'h00000, 8'h01, 1'b0, 1'b0, 8'h8C},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h8E},
      {A_REQ,  K_W, 18'h00000, 8'h84, 1'b1, 1'b0, 8'h85},
      {A_DONE, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h84},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h86},
      {A_REQ,  K_P, 18'h2FFFF, 8'h00, 1'b1, 1'b0, 8'h85},
      {A_DONE, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h84},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h86},
      {A_REQ,  K_S, 18'h30000, 8'h00, 1'b0, 1'b1, 8'h84},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h86},
      {A_REQ,  K_W, 18'h00000, 8'h08, 1'b1, 1'b0, 8'h09},
      {A_DONE, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h08},
      {A_PIN,  K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h08},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h0A},
      {A_REQ,  K_P, 18'h1FFFF, 8'h00, 1'b1, 1'b0, 8'h09},
      {A_DONE, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h08},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h0A},
      {A_REQ,  K_P, 18'h20000, 8'h00, 1'b0, 1'b1, 8'h08},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h0A},
      {A_REQ,  K_W, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h01},
      {A_DONE, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h00},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h02},
      {A_REQ,  K_W, 18'h00000, 8'h80, 1'b1, 1'b0, 8'h81},
      {A_DONE, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h80},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h82},
      {A_REQ,  K_W, 18'h00000, 8'h00, 1'b0, 1'b1, 8'h80},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h82},
      {A_REQ,  K_B, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h81},
      {A_DONE, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h80},
      {A_PIN,  K_P, 18'h00000, 8'h01, 1'b0, 1'b0, 8'h80},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h82},
      {A_REQ,  K_W, 18'h00000, 8'h73, 1'b1, 1'b0, 8'h01},
      {A_DONE, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h00},
      {A_DONE, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h00},
      {A_WRDI, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h00},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h02},
      {A_WREN, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h02},
      {A_REQ,  K_P, 18'h00000, 8'h00, 1'b1, 1'b0, 8'h01},
      {A_DONE, K_P, 18'h00000, 8'h00, 1'b0, 1'b0, 8'h00}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wp_n = 1'b1;
   logic          wren = 1'b0;
   logic          wrdi = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_wdata = 8'h00;
   logic          op_done = 1'b0;
   logic [7:0]    status;
   logic          grant;
   logic          refuse;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   flash_wp_unit #(.ADDR_W(AW), .WP_SYNC(2)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .wp_n_i      (wp_n),
      .wren_i      (wren),
      .wrdi_i      (wrdi),
      .req_valid_i (req_valid),
      .req_kind_i  (req_kind),
      .req_addr_i  (req_addr),
      .req_wdata_i (req_wdata),
      .op_done_i   (op_done),
      .status_o    (status),
      .req_grant_o (grant),
      .req_refuse_o(refuse)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [2:0] a, input logic [1:0] k);
      if (a == A_WREN || a == A_WRDI) return "R2";
      if (a == A_DONE) return "R5";
      if (a == A_PIN)  return "R8";
      if (k == K_B)    return "R10";
      if (k == K_W)    return "R7";
      return "R9";
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset value
      check("R1 reset status", status, 8'h00);
      check("R11 idle answers", {6'd0, grant, refuse}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         logic [40:0] v;
         string tg;
         v  = VEC[i];
         tg = tag_of(v[40:38], v[37:36]);
         @(negedge clk);
         wren      = (v[40:38] == A_WREN);
         wrdi      = (v[40:38] == A_WRDI);
         op_done   = (v[40:38] == A_DONE);
         req_valid = (v[40:38] == A_REQ);
         req_kind  = v[37:36];
         req_addr  = v[35:18];
         req_wdata = v[17:10];
         if (v[40:38] == A_PIN) wp_n = v[10];
         #1;
         // R11 same-cycle answer; R4 on vector 0, R6 where both expected low
         check($sformatf("R11 %s answer vec %0d", (v[9:8] == 2'b00 && v[40:38] == A_REQ) ? "R6" : tg, i),
               {6'd0, grant, refuse}, {6'd0, v[9], v[8]});
         @(negedge clk);
         wren = 1'b0; wrdi = 1'b0; op_done = 1'b0; req_valid = 1'b0;
         repeat (3) @(negedge clk);
         // R3 latch cleared after requests; R1 layout on every vector
         check($sformatf("%s R3 R1 status vec %0d", tg, i), status, v[7:0]);
      end

      // R1: mid-run reset returns to 00h
      @(negedge clk);
      wren = 1'b1;
      @(negedge clk);
      wren = 1'b0;
      check("R2 latch set before reset", status, 8'h02);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 status after reset", status, 8'h00);

      // R4: request straight after reset is refused
      req_valid = 1'b1; req_kind = K_S; req_addr = '0;
      #1;
      check("R4 refused without latch", {6'd0, grant, refuse}, 8'h01);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      check("R3 refused leaves idle", status, 8'h00);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule